// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block is a small, fully associative cache of page translations. It sits between a processor's address path and memory. Each load, store or instruction fetch presents a virtual address. The virtual page number is compared against every valid entry in the same cycle. On a hit, the physical address is formed by joining the stored physical page number to the unchanged page offset. On a miss, the block raises a miss trap and carries the faulting virtual address. It never walks a page table itself.

Privileged software handles the trap and installs the translation through a separate write port. The hardware picks the slot. If the virtual page is already present, that slot is reused. Otherwise the first free slot is taken. When no slot is free, a reference-bit approximation of least-recently-used chooses the victim. The hardware also keeps a per-entry reference bit and dirty bit, and it checks a two-bit rights field on every lookup. An access that breaks the rights raises a protection fault instead of returning a translation.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid and all response outputs are zero, so the first lookup misses.
- R2: A lookup that matches a valid entry and passes the rights check gives `rsp_hit` with `rsp_paddr` = {stored physical page, the lookup's page offset}. It also reports the matching slot on `rsp_slot`.
- R3: A lookup that matches no valid entry gives `rsp_miss` with the lookup's address on `rsp_vaddr`. In that case `rsp_paddr`, `rsp_slot` and `rsp_dirty` are zero.
- R4: Responses appear in the cycle after the lookup is presented. `rsp_hit`, `rsp_miss` and `rsp_fault` are never high together, and all three are low after a cycle with no lookup.
- R5: Writing an entry whose virtual page matches a valid entry overwrites that slot. No duplicate is created, and the overwritten entry's reference and dirty bits start at zero.
- R6: A write whose page is not present goes to the lowest-numbered invalid slot.
- R7: When all slots are valid, a write goes to the lowest-numbered slot whose reference bit is clear. The reference bit is set by every successful hit and cleared when an entry is written.
- R8: When all slots are valid and every reference bit is set, a write clears all reference bits and goes to slot 0.
- R9: A store that hits and passes the rights check sets the entry's dirty bit. `rsp_dirty` on a hit shows that bit as it stood before the lookup.
- R10: Rights bit 0 means writable and rights bit 1 means visible to user mode. A user-mode lookup (`lk_user`=1) of an entry with bit 1 clear faults. A store (`lk_kind`=1) to an entry with bit 0 clear faults in either mode. A fault gives `rsp_fault` with zero `rsp_paddr`, and it changes neither the reference bit nor the dirty bit. Load is `lk_kind`=0 and fetch is `lk_kind`=2.
- R11: `flush` invalidates every entry within one cycle. A write presented in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address of the lookup |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_user | input | 1 | Lookup is made in user mode |
| wr_en | input | 1 | Install a translation |
| wr_vpn | input | VA_W-OFF_W | Virtual page number to install |
| wr_ppn | input | PA_W-OFF_W | Physical page number to install |
| wr_rights | input | 2 | Rights: bit 0 writable, bit 1 user-visible |
| rsp_hit | output | 1 | Translation returned |
| rsp_miss | output | 1 | Miss trap |
| rsp_fault | output | 1 | Protection fault |
| rsp_paddr | output | PA_W | Physical address on hit |
| rsp_vaddr | output | VA_W | Virtual address of the answered lookup |
| rsp_slot | output | log2(ENTRIES) | Slot that hit |
| rsp_dirty | output | 1 | Dirty bit of the hit slot before the lookup |

## Verification
A victim chosen wrongly stays hidden until a later lookup lands in an unexpected `rsp_slot`, or misses on a page that should have survived. For that reason the bench installs entries and then reads back their slot numbers. It drives the reference bits through full cycles of setting and clearing. A stale dirty or reference bit shows up only one or two lookups later, in `rsp_dirty` or in the next replacement. A wrong rights decision shows in the very next response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int RIGHT_WR   = 0;
    localparam int RIGHT_USER = 1;

    typedef struct packed {
        logic hit;
        logic miss;
        logic fault;
    } rsp_flags_t;

    function automatic logic rights_ok(input logic [1:0] rights,
                                       input acc_kind_e  kind,
                                       input logic       user);
        logic ok;
        ok = 1'b1;
        if (user && !rights[RIGHT_USER])
            ok = 1'b0;
        if (kind == ACC_STORE && !rights[RIGHT_WR])
            ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ENTRIES-1:0]              valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab,
    input  logic [VPN_W-1:0]                key,
    output logic [ENTRIES-1:0]              hit_vec,
    output logic                            any_hit,
    output logic [IDX_W-1:0]                hit_idx
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = valid[e] && (vpn_tab[e] == key);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec[e])
                hit_idx = IDX_W'(e);
        end
    end

    // R5: installs never leave two valid copies of one page
    p_unique_match_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] refb,
    output logic [IDX_W-1:0]   idx,
    output logic               sweep
);

    logic             inv_found, unref_found;
    logic [IDX_W-1:0] inv_idx, unref_idx;

    always_comb begin
        inv_found   = 1'b0;
        unref_found = 1'b0;
        inv_idx     = '0;
        unref_idx   = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!valid[e]) begin
                inv_found = 1'b1;
                inv_idx   = IDX_W'(e);
            end
            if (!refb[e]) begin
                unref_found = 1'b1;
                unref_idx   = IDX_W'(e);
            end
        end
    end

    always_comb begin
        sweep = 1'b0;
        if (inv_found)
            idx = inv_idx;
        else if (unref_found)
            idx = unref_idx;
        else begin
            idx   = '0;
            sweep = 1'b1;
        end
    end

    // R6: a free slot is always preferred
    p_victim_free_r6: assert property (@(posedge clk) disable iff (rst)
        !(&valid) |-> !valid[idx]);
    // R7: with the table full, an unreferenced slot is chosen if one exists
    p_victim_unref_r7: assert property (@(posedge clk) disable iff (rst)
        ((&valid) && !(&refb)) |-> (!refb[idx] && !sweep));

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            flush,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [VPN_W-1:0]                wr_vpn,
    input  logic [PPN_W-1:0]                wr_ppn,
    input  logic [1:0]                      wr_rights,
    input  logic                            sweep,
    input  logic                            hit_upd,
    input  logic [IDX_W-1:0]                hit_idx,
    input  logic                            set_dirty,
    output logic [ENTRIES-1:0]              valid,
    output logic [ENTRIES-1:0]              refb,
    output logic [ENTRIES-1:0]              dirty,
    output logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab,
    output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_tab,
    output logic [ENTRIES-1:0][1:0]         rights_tab
);

    logic wr_go;
    assign wr_go = wr_en && !flush;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic             v_q, r_q, d_q;
        logic [VPN_W-1:0] vpn_q;
        logic [PPN_W-1:0] ppn_q;
        logic [1:0]       rt_q;
        logic             mine_wr, mine_hit;

        assign mine_wr  = wr_go && (wr_idx == IDX_W'(e));
        assign mine_hit = hit_upd && (hit_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q   <= 1'b0;
                r_q   <= 1'b0;
                d_q   <= 1'b0;
                vpn_q <= '0;
                ppn_q <= '0;
                rt_q  <= '0;
            end else if (flush) begin
                v_q <= 1'b0;
            end else if (mine_wr) begin
                v_q   <= 1'b1;
                r_q   <= 1'b0;
                d_q   <= 1'b0;
                vpn_q <= wr_vpn;
                ppn_q <= wr_ppn;
                rt_q  <= wr_rights;
            end else begin
                if (wr_go && sweep)
                    r_q <= 1'b0;
                if (mine_hit)
                    r_q <= 1'b1;
                if (mine_hit && set_dirty)
                    d_q <= 1'b1;
            end
        end

        assign valid[e]      = v_q;
        assign refb[e]       = r_q;
        assign dirty[e]      = d_q;
        assign vpn_tab[e]    = vpn_q;
        assign ppn_tab[e]    = ppn_q;
        assign rights_tab[e] = rt_q;

        // R9: a dirty bit only rises after a permitted store hit on this slot
        p_dirty_cause_r9: assert property (@(posedge clk) disable iff (rst)
            $rose(d_q) |-> $past(mine_hit && set_dirty));
    end

    // R11: flush empties the table by the next cycle
    p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid == '0));

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        lk_valid,
    input  logic [VA_W-1:0]             lk_vaddr,
    input  logic [1:0]                  lk_kind,
    input  logic                        lk_user,
    input  logic                        wr_en,
    input  logic [VA_W-OFF_W-1:0]       wr_vpn,
    input  logic [PA_W-OFF_W-1:0]       wr_ppn,
    input  logic [1:0]                  wr_rights,
    output logic                        rsp_hit,
    output logic                        rsp_miss,
    output logic                        rsp_fault,
    output logic [PA_W-1:0]             rsp_paddr,
    output logic [VA_W-1:0]             rsp_vaddr,
    output logic [$clog2(ENTRIES)-1:0]  rsp_slot,
    output logic                        rsp_dirty
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]            valid, refb, dirty;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_tab;
    logic [ENTRIES-1:0][1:0]       rights_tab;

    logic [ENTRIES-1:0] lk_vec, wm_vec;
    logic               lk_any, wm_any;
    logic [IDX_W-1:0]   lk_idx, wm_idx, vic_idx, wr_idx;
    logic               vic_sweep, sweep_go;

    acc_kind_e  kind;
    logic       ok, hit_upd, set_dirty;
    rsp_flags_t flags_d, flags_q;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
        .clk(clk), .rst(rst), .valid(valid), .vpn_tab(vpn_tab),
        .key(lk_vaddr[VA_W-1:OFF_W]),
        .hit_vec(lk_vec), .any_hit(lk_any), .hit_idx(lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_wr_match (
        .clk(clk), .rst(rst), .valid(valid), .vpn_tab(vpn_tab),
        .key(wr_vpn),
        .hit_vec(wm_vec), .any_hit(wm_any), .hit_idx(wm_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst(rst), .valid(valid), .refb(refb),
        .idx(vic_idx), .sweep(vic_sweep)
    );

    assign wr_idx   = wm_any ? wm_idx : vic_idx;
    assign sweep_go = !wm_any && vic_sweep;

    assign kind      = acc_kind_e'(lk_kind);
    assign ok        = rights_ok(rights_tab[lk_idx], kind, lk_user);
    assign hit_upd   = lk_valid && lk_any && ok;
    assign set_dirty = (kind == ACC_STORE);

    tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_rights(wr_rights), .sweep(sweep_go),
        .hit_upd(hit_upd), .hit_idx(lk_idx), .set_dirty(set_dirty),
        .valid(valid), .refb(refb), .dirty(dirty),
        .vpn_tab(vpn_tab), .ppn_tab(ppn_tab), .rights_tab(rights_tab)
    );

    always_comb begin
        flags_d.hit   = hit_upd;
        flags_d.miss  = lk_valid && !lk_any;
        flags_d.fault = lk_valid && lk_any && !ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            rsp_paddr <= '0;
            rsp_vaddr <= '0;
            rsp_slot  <= '0;
            rsp_dirty <= 1'b0;
        end else begin
            flags_q   <= flags_d;
            rsp_vaddr <= lk_valid ? lk_vaddr : '0;
            rsp_paddr <= flags_d.hit ? {ppn_tab[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
            rsp_slot  <= flags_d.hit ? lk_idx : '0;
            rsp_dirty <= flags_d.hit ? dirty[lk_idx] : 1'b0;
        end
    end

    assign rsp_hit   = flags_q.hit;
    assign rsp_miss  = flags_q.miss;
    assign rsp_fault = flags_q.fault;

    // R4: at most one outcome per response
    p_one_outcome_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit, rsp_miss, rsp_fault}));
    // R4: no request, no response
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !(rsp_hit || rsp_miss || rsp_fault));
    // R3: an unmatched page traps with its address next cycle
    p_miss_trap_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_any) |=> (rsp_miss && rsp_vaddr == $past(lk_vaddr)));
    // R2: the page offset passes through untouched
    p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));
    // R10: a fault returns no translation
    p_fault_no_addr_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0));

endmodule

// File: tb/soft_tlb_test.sv
module soft_tlb_test;

    localparam int VA_W = 32, PA_W = 32, OFF_W = 12, ENTRIES = 16;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int VPN_W = VA_W - OFF_W, PPN_W = PA_W - OFF_W;

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic lk_valid = 1'b0, lk_user = 1'b0, wr_en = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic [1:0]       lk_kind = '0, wr_rights = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [PPN_W-1:0] wr_ppn = '0;
    logic rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [PA_W-1:0]  rsp_paddr;
    logic [VA_W-1:0]  rsp_vaddr;
    logic [IDX_W-1:0] rsp_slot;

    soft_tlb #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) uut (
        .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .lk_user(lk_user), .wr_en(wr_en), .wr_vpn(wr_vpn),
        .wr_ppn(wr_ppn), .wr_rights(wr_rights), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr),
        .rsp_slot(rsp_slot), .rsp_dirty(rsp_dirty)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int              due;
        int              req;
        logic [2:0]      flags;   // {hit, miss, fault}
        logic [PA_W-1:0] pa;
        logic [VA_W-1:0] va;
        logic [IDX_W-1:0] slot;
        logic            dirty;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0, checks = 0, failures = 0;
    bit   done = 0;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;
    localparam int HIT = 0, MISS = 1, FLT = 2;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                exp_t x;
                x = exp_q.pop_front();
                checks++;
                if ({rsp_hit, rsp_miss, rsp_fault} !== x.flags || rsp_paddr !== x.pa ||
                    rsp_vaddr !== x.va || rsp_slot !== x.slot || rsp_dirty !== x.dirty) begin
                    failures++;
                    $display("FAIL R%0d: got flags=%b pa=%h va=%h slot=%0d dirty=%b exp flags=%b pa=%h va=%h slot=%0d dirty=%b",
                             x.req, {rsp_hit, rsp_miss, rsp_fault}, rsp_paddr, rsp_vaddr,
                             rsp_slot, rsp_dirty, x.flags, x.pa, x.va, x.slot, x.dirty);
                end
            end else begin
                checks++; // R4: idle cycle stays quiet
                if ({rsp_hit, rsp_miss, rsp_fault} !== 3'b000) begin
                    failures++;
                    $display("FAIL R4: idle flags=%b exp 000", {rsp_hit, rsp_miss, rsp_fault});
                end
            end
        end
    end

    task automatic install(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                           input logic [1:0] rt, input bit fl = 0);
        wr_en = 1; wr_vpn = v; wr_ppn = p; wr_rights = rt; flush = fl;
        @(negedge clk);
        wr_en = 0; flush = 0;
    endtask

    task automatic look(input logic [VA_W-1:0] va, input logic [1:0] kind, input bit user,
                        input int outcome, input logic [PPN_W-1:0] ppn,
                        input int slot, input bit dty, input int req);
        exp_t x;
        lk_valid = 1; lk_vaddr = va; lk_kind = kind; lk_user = user;
        x.due = cyc + 1; x.req = req; x.va = va;
        x.flags = (outcome == HIT) ? 3'b100 : (outcome == MISS) ? 3'b010 : 3'b001;
        x.pa    = (outcome == HIT) ? {ppn, va[OFF_W-1:0]} : '0;
        x.slot  = (outcome == HIT) ? IDX_W'(slot) : '0;
        x.dirty = (outcome == HIT) ? dty : 1'b0;
        exp_q.push_back(x);
        @(negedge clk);
        lk_valid = 0;
    endtask

    function automatic logic [VA_W-1:0] mk(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o);
        return {v, o};
    endfunction

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog: run did not finish, exp done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        checks++; // R1: outputs clear after reset
        if ({rsp_hit, rsp_miss, rsp_fault, rsp_dirty} !== 4'b0 || rsp_paddr !== '0) begin
            failures++;
            $display("FAIL R1: flags=%b pa=%h exp zero", {rsp_hit, rsp_miss, rsp_fault}, rsp_paddr);
        end
        look(32'h1234_5678, LD, 1, MISS, 0, 0, 0, 1);        // R1 and R3
        // R6 / R2: first install lands in slot 0
        install(20'h12345, 20'hABCDE, 2'b11);
        look(mk(20'h12345, 12'h678), LD, 1, HIT, 20'hABCDE, 0, 0, 2);
        look(mk(20'h12345, 12'hFFF), FE, 0, HIT, 20'hABCDE, 0, 0, 2);
        // R10: kernel-only writable page
        install(20'h00010, 20'h00042, 2'b01);
        look(mk(20'h00010, 12'h004), LD, 1, FLT, 0, 0, 0, 10);
        look(mk(20'h00010, 12'h004), LD, 0, HIT, 20'h00042, 1, 0, 6);
        // R10: user read-only page; failed stores leave dirty clear
        install(20'h00020, 20'h00077, 2'b10);
        look(mk(20'h00020, 12'h010), ST, 1, FLT, 0, 0, 0, 10);
        look(mk(20'h00020, 12'h010), ST, 0, FLT, 0, 0, 0, 10);
        look(mk(20'h00020, 12'h011), LD, 1, HIT, 20'h00077, 2, 0, 10);
        // R9: store sets dirty, visible on the next hit
        look(mk(20'h12345, 12'h000), ST, 1, HIT, 20'hABCDE, 0, 0, 9);
        look(mk(20'h12345, 12'h001), LD, 1, HIT, 20'hABCDE, 0, 1, 9);
        // R5: rewriting the same page reuses slot 0 and clears dirty
        install(20'h12345, 20'h11111, 2'b11);
        look(mk(20'h12345, 12'h678), FE, 1, HIT, 20'h11111, 0, 0, 5);
        // fill slots 3..15 (R6)
        for (int i = 3; i < ENTRIES; i++)
            install(VPN_W'(32'h100 + i), PPN_W'(32'h300 + i), 2'b11);
        look(mk(20'h0010F, 12'h0AB), LD, 0, HIT, 20'h0030F, 15, 0, 6);
        // R7: full table, lowest unreferenced slot is 3
        install(20'h00200, 20'h00500, 2'b11);
        look(mk(20'h00200, 12'h020), LD, 0, HIT, 20'h00500, 3, 0, 7);
        look(mk(20'h00103, 12'h020), LD, 0, MISS, 0, 0, 0, 7);
        install(20'h00201, 20'h00501, 2'b11);
        look(mk(20'h00201, 12'h021), LD, 0, HIT, 20'h00501, 4, 0, 7);
        for (int i = 5; i < 15; i++)
            look(mk(VPN_W'(32'h100 + i), 12'h3), LD, 0, HIT, PPN_W'(32'h300 + i), i, 0, 7);
        // R8: every reference bit set: sweep, take slot 0
        install(20'h00202, 20'h00502, 2'b11);
        look(mk(20'h00202, 12'h022), LD, 0, HIT, 20'h00502, 0, 0, 8);
        look(mk(20'h12345, 12'h022), LD, 0, MISS, 0, 0, 0, 8);
        install(20'h00203, 20'h00503, 2'b11);
        look(mk(20'h00203, 12'h023), LD, 0, HIT, 20'h00503, 1, 0, 8);
        look(mk(20'h0010F, 12'h023), LD, 0, HIT, 20'h0030F, 15, 0, 8);
        // R11: flush wins over a same-cycle write
        install(20'h00300, 20'h00600, 2'b11, 1);
        look(mk(20'h00300, 12'h030), LD, 0, MISS, 0, 0, 0, 11);
        look(mk(20'h00202, 12'h030), LD, 0, MISS, 0, 0, 0, 11);
        look(mk(20'h0010F, 12'h030), LD, 0, MISS, 0, 0, 0, 11);
        install(20'h00300, 20'h00600, 2'b11);
        look(mk(20'h00300, 12'h031), ST, 0, HIT, 20'h00600, 0, 0, 11);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R4: %0d responses never arrived, exp 0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule